// File: doc/BRIEF.md
# Terminal-Side Layer-1 Activation Controller

This block decides, for a terminal attached to a four-wire basic-rate S/T interface, when layer 1 is asleep, waking or up. It takes decoded indications from the line receiver (idle line, the network's framing signal with or without activation, loss of framing) plus host activate and deactivate requests. From these it chooses which signal the terminal transmits: silence, the wake-up request, or framed data. It reports a 3-bit state code the host can read at any time.

The block also contains an any-signal detector. It watches the received bit stream, one bit per qualified cycle, and declares that the line is alive when three pulse bits (binary zeros on the line) fall within any 48 consecutive received bits. The pending group of states has two members. `REQ` is the terminal asking for activation. `HEARD` is the terminal having detected line activity. The synchronized and lost-framing conditions share one state, `SYNC`.

Top module: `st_te_act_ctrl`

States (code): `IDLE`=0 deactivated, `REQ`=1 pending and requesting, `HEARD`=2 pending with line activity heard, `SYNC`=3 synchronized or framing lost, `UP`=4 activated. Transmit codes: silence=2'b00, wake-up request=2'b01, framed=2'b11.

Named transitions:
- IDLE→REQ on an activate request.
- IDLE/REQ→HEARD on any-signal.
- IDLE/REQ/HEARD→SYNC on INFO2 or INFO4.
- REQ/HEARD→IDLE on a deactivate request.
- SYNC→UP on INFO4 with framing held.
- UP→SYNC on lost framing.
- SYNC/UP→IDLE on INFO0.

Priority runs from INFO2/INFO4, then INFO0, then deactivate request, then any-signal, then activate request.

## Requirements
- R1: After reset the state code is 0 (IDLE), the transmit code is 2'b00 and the deactivation indication is low.
- R2: In IDLE, an activate request with no INFO2/INFO4 and no any-signal moves to REQ (code 1), transmitting 2'b01.
- R3: Any-signal is declared when three pulse bits lie within 48 consecutive received bits; fewer pulses, or a span longer than 48 bits, is not. In IDLE or REQ, any-signal moves to HEARD (code 2), transmitting 2'b00.
- R4: INFO2 or INFO4 in IDLE, REQ or HEARD moves to SYNC (code 3), transmitting 2'b11, ahead of any request or any-signal.
- R5: In SYNC, INFO4 without lost framing moves to UP (code 4), transmitting 2'b11. INFO4 with lost framing stays in SYNC.
- R6: In UP, lost framing without INFO0 moves to SYNC, not to IDLE.
- R7: INFO0 in SYNC or UP moves to IDLE. The deactivation indication is high for exactly the first cycle in IDLE.
- R8: A deactivate request in REQ or HEARD moves to IDLE with no deactivation indication.
- R9: Activate requests in HEARD, SYNC or UP, and deactivate requests in IDLE, SYNC or UP, change neither the state nor the transmit code.
- R10: Entering IDLE empties the any-signal window, so pulses received before entry do not count toward a later detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_info0_i | input | 1 | Receiver reports INFO0 (no signal) |
| rx_info2_i | input | 1 | Receiver reports INFO2 |
| rx_info4_i | input | 1 | Receiver reports INFO4 |
| rx_lost_sync_i | input | 1 | Receiver reports loss of framing |
| rx_bit_vld_i | input | 1 | A received bit is presented this cycle |
| rx_bit_mark_i | input | 1 | 1 when the presented bit is a pulse (binary zero) |
| host_act_req_i | input | 1 | Host activate request |
| host_deact_req_i | input | 1 | Host deactivate request |
| state_o | output | 3 | State code (0..4) |
| tx_info_o | output | 2 | Transmit code: 00 silence, 01 wake-up, 11 framed |
| deact_ind_o | output | 1 | One-cycle deactivation indication |

## Verification
Line indications and requests are sampled on a rising edge. The state, transmit code and deactivation indication show the result right after that edge, so the bench drives on a falling edge and checks on the next falling edge.

Any-signal takes one edge longer. The detector's window count registers the third pulse on one edge, and the state machine acts on it on the following edge. Window tests therefore present one idle cycle after the last bit before checking.

The bench checks every start state against every combination of the six line and host inputs. It also checks the window span on both sides of 48 bits, the one-cycle indication width and the window flush.

// File: rtl/st_act_pkg.sv
package st_act_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_HEARD = 3'd2,
        ST_SYNC  = 3'd3,
        ST_UP    = 3'd4
    } te_state_e;

    typedef enum logic [1:0] {
        TX_SILENT  = 2'b00,
        TX_WAKE    = 2'b01,
        TX_FRAMED  = 2'b11
    } tx_sig_e;

    typedef struct packed {
        logic inf0;
        logic inf2;
        logic inf4;
        logic lost;
    } rx_ind_t;

endpackage

// File: rtl/st_any_sig_det.sv
module st_any_sig_det #(
    parameter int WIN_LEN = 48,
    parameter int HIT_CNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic bit_vld_i,
    input  logic bit_mark_i,
    output logic any_sig_o
);
    localparam int CW = $clog2(WIN_LEN + 1);

    logic [WIN_LEN-1:0] win_q;
    logic [CW-1:0]      cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (flush_i) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (bit_vld_i) begin
            win_q <= {win_q[WIN_LEN-2:0], bit_mark_i};
            cnt_q <= cnt_q + CW'(bit_mark_i) - CW'(win_q[WIN_LEN-1]);
        end
    end

    assign any_sig_o = (cnt_q >= CW'(HIT_CNT));

    // R3: the running pulse count always equals the pulses held in the window
    a_r3_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == CW'($countones(win_q)));

    // R10: a flush leaves nothing in the window
    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_q == '0) && !any_sig_o);

endmodule

// File: rtl/st_te_fsm.sv
module st_te_fsm
    import st_act_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rx_ind_t   rx_i,
    input  logic      any_sig_i,
    input  logic      act_req_i,
    input  logic      deact_req_i,
    output logic      flush_o,
    output logic [2:0] state_o,
    output logic [1:0] tx_o,
    output logic      deact_ind_o
);
    te_state_e state_q, state_d;
    logic      net_deact;
    logic      deact_q;

    // next-state selection
    always_comb begin
        state_d   = state_q;
        net_deact = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_i.inf2 || rx_i.inf4) state_d = ST_SYNC;
                else if (any_sig_i)         state_d = ST_HEARD;
                else if (act_req_i)         state_d = ST_REQ;
            end
            ST_REQ: begin
                if (rx_i.inf2 || rx_i.inf4) state_d = ST_SYNC;
                else if (deact_req_i)       state_d = ST_IDLE;
                else if (any_sig_i)         state_d = ST_HEARD;
            end
            ST_HEARD: begin
                if (rx_i.inf2 || rx_i.inf4) state_d = ST_SYNC;
                else if (deact_req_i)       state_d = ST_IDLE;
            end
            ST_SYNC: begin
                if (rx_i.inf0) begin
                    state_d   = ST_IDLE;
                    net_deact = 1'b1;
                end else if (rx_i.inf4 && !rx_i.lost) begin
                    state_d = ST_UP;
                end
            end
            ST_UP: begin
                if (rx_i.inf0) begin
                    state_d   = ST_IDLE;
                    net_deact = 1'b1;
                end else if (rx_i.lost) begin
                    state_d = ST_SYNC;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign flush_o = (state_d == ST_IDLE) && (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            deact_q <= 1'b0;
        end else begin
            state_q <= state_d;
            deact_q <= net_deact;
        end
    end

    // outputs
    always_comb begin
        tx_o = TX_SILENT;
        unique case (state_q)
            ST_IDLE:  tx_o = TX_SILENT;
            ST_REQ:   tx_o = TX_WAKE;
            ST_HEARD: tx_o = TX_SILENT;
            ST_SYNC:  tx_o = TX_FRAMED;
            ST_UP:    tx_o = TX_FRAMED;
            default:  tx_o = TX_SILENT;
        endcase
        state_o     = state_q;
        deact_ind_o = deact_q;
    end

    // R2: wake request from idle
    a_r2_idle_to_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && act_req_i && !any_sig_i && !rx_i.inf2 && !rx_i.inf4
        |=> (state_o == 3'd1) && (tx_o == 2'b01));

    // R3: heard line activity while waiting
    a_r3_heard: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) || (state_q == ST_REQ && !deact_req_i)) && any_sig_i
        && !rx_i.inf2 && !rx_i.inf4 |=> state_o == 3'd2);

    // R4: network framing seen from any pending state
    a_r4_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_IDLE, ST_REQ, ST_HEARD}) && (rx_i.inf2 || rx_i.inf4)
        |=> (state_o == 3'd3) && (tx_o == 2'b11));

    // R6: lost framing while up never drops straight to idle
    a_r6_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP) && rx_i.lost && !rx_i.inf0 |=> state_o == 3'd3);

    // R7: indication lasts one cycle and only in idle
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        deact_ind_o |=> !deact_ind_o);
    a_r7_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        deact_ind_o |-> state_o == 3'd0);

    // R9: requests in up state have no effect
    a_r9_up_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP) && !rx_i.inf0 && !rx_i.lost |=> state_o == 3'd4);

endmodule

// File: rtl/st_te_act_ctrl.sv
module st_te_act_ctrl #(
    parameter int WIN_LEN = 48,
    parameter int HIT_CNT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_info0_i,
    input  logic       rx_info2_i,
    input  logic       rx_info4_i,
    input  logic       rx_lost_sync_i,
    input  logic       rx_bit_vld_i,
    input  logic       rx_bit_mark_i,
    input  logic       host_act_req_i,
    input  logic       host_deact_req_i,
    output logic [2:0] state_o,
    output logic [1:0] tx_info_o,
    output logic       deact_ind_o
);
    import st_act_pkg::*;

    rx_ind_t rx_ind;
    logic    any_sig;
    logic    flush;

    assign rx_ind = '{inf0: rx_info0_i, inf2: rx_info2_i,
                      inf4: rx_info4_i, lost: rx_lost_sync_i};

    st_any_sig_det #(.WIN_LEN(WIN_LEN), .HIT_CNT(HIT_CNT)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .bit_vld_i  (rx_bit_vld_i),
        .bit_mark_i (rx_bit_mark_i),
        .any_sig_o  (any_sig)
    );

    st_te_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_i        (rx_ind),
        .any_sig_i   (any_sig),
        .act_req_i   (host_act_req_i),
        .deact_req_i (host_deact_req_i),
        .flush_o     (flush),
        .state_o     (state_o),
        .tx_o        (tx_info_o),
        .deact_ind_o (deact_ind_o)
    );

    // R1: state code stays in the defined range
    a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

endmodule

// File: tb/sim_st_te_act_ctrl.sv
module sim_st_te_act_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i0 = 0, i2 = 0, i4 = 0, ls = 0, bv = 0, bm = 0, ar = 0, dr = 0;
    logic [2:0] st;
    logic [1:0] tx;
    logic dind;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    st_te_act_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_info0_i(i0), .rx_info2_i(i2), .rx_info4_i(i4), .rx_lost_sync_i(ls),
        .rx_bit_vld_i(bv), .rx_bit_mark_i(bm),
        .host_act_req_i(ar), .host_deact_req_i(dr),
        .state_o(st), .tx_info_o(tx), .deact_ind_o(dind)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_in();
        {i0, i2, i4, ls, bv, bm, ar, dr} = '0;
    endtask

    task automatic cyc();
        @(negedge clk);
        idle_in();
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic feed_bit(input logic mark);
        bv = 1'b1; bm = mark; cyc();
    endtask

    // bring the design to a given state code
    task automatic go_to(input int s);
        do_reset();
        case (s)
            1: begin ar = 1; cyc(); end
            2: begin feed_bit(1); feed_bit(1); feed_bit(1); cyc(); end
            3: begin i2 = 1; cyc(); end
            4: begin i2 = 1; cyc(); i4 = 1; cyc(); end
            default: ;
        endcase
    endtask

    function automatic int exp_next(int s, logic a, logic d, logic z0,
                                    logic z2, logic z4, logic l);
        case (s)
            0: return (z2 | z4) ? 3 : (a ? 1 : 0);
            1: return (z2 | z4) ? 3 : (d ? 0 : 1);
            2: return (z2 | z4) ? 3 : (d ? 0 : 2);
            3: return z0 ? 0 : ((z4 && !l) ? 4 : 3);
            4: return z0 ? 0 : (l ? 3 : 4);
            default: return 0;
        endcase
    endfunction

    function automatic int exp_tx(int s);
        return (s == 1) ? 1 : ((s >= 3) ? 3 : 0);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 state", st, 0);
        chk("R1 tx", tx, 0);
        chk("R1 deact_ind", dind, 0);

        // R2 R4 R5 R6 R7 R8 R9: every start state against every input mix
        for (int s = 0; s < 5; s++) begin
            for (int e = 0; e < 64; e++) begin
                int nx;
                go_to(s);
                chk("R2/R3/R4/R5 reach", st, s);
                {ar, dr, i0, i2, i4, ls} = e[5:0];
                nx = exp_next(s, e[5], e[4], e[3], e[2], e[1], e[0]);
                cyc();
                if (s >= 3 && e[3]) chk("R7 state", st, nx);
                else if (s == 4 && e[0]) chk("R6 state", st, nx);
                else if ((e[5] || e[4]) && !e[2] && !e[1]) chk("R9 R8 R2 state", st, nx);
                else chk("R4 R5 state", st, nx);
                chk("R5 tx", tx, exp_tx(nx));
                chk("R7 R8 deact_ind", dind, (s >= 3 && e[3]) ? 1 : 0);
                cyc();
                chk("R7 single cycle", dind, 0);
            end
        end

        // R3 window span sweep: pulses at bits 0, 1 and g
        for (int g = 40; g <= 56; g++) begin
            do_reset();
            for (int b = 0; b <= g; b++) feed_bit((b == 0) || (b == 1) || (b == g));
            cyc();
            chk("R3 span", st, (g <= 47) ? 2 : 0);
            chk("R3 tx", tx, 0);
        end

        // R3 two pulses only, and detection from REQ
        do_reset();
        feed_bit(1); feed_bit(0); feed_bit(1);
        repeat (5) feed_bit(0);
        cyc();
        chk("R3 two pulses", st, 0);
        ar = 1; cyc();
        chk("R2 req", st, 1);
        feed_bit(1); cyc();
        chk("R3 from req", st, 2);

        // R3 invalid cycles do not shift the window
        do_reset();
        feed_bit(1);
        repeat (60) cyc();
        feed_bit(1); feed_bit(1); cyc();
        chk("R3 qualified bits only", st, 2);

        // R10 flush on entering idle
        do_reset();
        feed_bit(1); feed_bit(1);
        ar = 1; cyc();
        dr = 1; cyc();
        chk("R10 back idle", st, 0);
        feed_bit(1); cyc();
        chk("R10 flushed", st, 0);
        feed_bit(1); feed_bit(1); cyc();
        chk("R10 fresh detect", st, 2);

        // R7 deactivation from UP flushes and pulses once
        go_to(4);
        i0 = 1; cyc();
        chk("R7 idle", st, 0);
        chk("R7 ind", dind, 1);
        cyc();
        chk("R7 ind low", dind, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule